// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves one byte in each direction at once over a three-wire synchronous link: a transfer clock, a serial data output and a serial data input. Software programs an 8-bit control register and an 8-bit divider register, then writes a byte into the shared data register. That write starts the exchange. Eight bits leave the data output while eight bits are shifted in from the data input. When the eighth incoming bit has been captured, a one-cycle `done` pulse is raised, and the same data register then reads back the received byte.

The transfer clock comes from one of two places. It can be made inside the block from the system clock, through a selectable prescaler of 1, 8 or 32 followed by a programmable divide of n+1. It can also be taken from an external clock pin, which passes through a two-flop synchronizer before its edges are detected. The clock polarity, the bit order, a high-impedance control for the data output and a fixed output level for when the serial function is off are all set in the control register.

Top module: `sio_unit`

## Requirements
- R1: After reset the control register reads 0x40, the status busy bit (address 3, bit 0) is 0, `done` is 0, `sdo` is 0, `sdo_oe` is 1 and `sclk_oe` is 0.
- R2: The register map is: address 0 is the data register, 1 is control, 2 is the divider (write-only, reads 0x00) and 3 is status with busy in bit 0. `reg_rdata` shows the register selected by `reg_addr` one clock later.
- R3: Control bits [1:0] pick the prescale factor P: 00 gives 1, 01 gives 8, 10 gives 32. The reserved code 11 behaves as 32.
- R4: With internal clock and divider value n, each transfer-clock half period lasts H=(n+1)*P system clocks. `done` is high for exactly one cycle, 16*H clocks after the clock edge that accepted the data write.
- R5: Control bit 4 (pol) sets the clock polarity. The transfer clock idles at the inverse of pol. The edge leaving idle (launch) updates `sdo`, and the edge returning to idle (capture) samples `sdi`.
- R6: Control bit 5 set means MSB first on both the output and the input. Clear means LSB first.
- R7: Control bit 6 set uses the internal clock and drives it out (`sclk_oe` = bit3 AND bit6, registered). Clear uses `sclk_ext` through a two-flop synchronizer.
- R8: With control bit 3 set, control bit 2 set drives `sdo_oe` low one clock after the control write.
- R9: With control bit 3 clear, `sdo` takes the value of control bit 7 and `sdo_oe` is 1, one clock after the control write.
- R10: After `done`, the data register reads the byte received on `sdi`, and the byte written was delivered on `sdo`.
- R11: Writes to the data register or the divider are ignored while busy. This includes a data write accepted on the same edge as the final capture.
- R12: Busy is set by the edge that accepts a data write and clears on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| done | output | 1 | One-cycle transfer-complete pulse |
| sclk_ext | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock output |
| sclk_oe | output | 1 | Clock output enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Data output enable (0 = high impedance) |

## Verification
The two actions that can meet in one cycle are a new data-register write and the final capture that ends the current byte. The bench counts exactly 16*H clocks from the start edge and holds a data write with a different value on the edge that raises `done`. It then expects busy to read 0 and the data register to hold the received byte rather than the intruding value. A second intrusion, made mid-transfer, rewrites both the divider and the data register; the bench expects the transfer length and the byte sent to stay unchanged.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
  localparam int B_HIZ  = 2;
  localparam int B_EN   = 3;
  localparam int B_POL  = 4;
  localparam int B_MSB  = 5;
  localparam int B_INT  = 6;
  localparam int B_IDLE = 7;
  localparam logic [7:0] CTRL_RST = 8'h40;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int DIV_W  = 8,
  parameter int PS_MID = 8,
  parameter int PS_HI  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [1:0]       sel,
  input  logic [DIV_W-1:0] div,
  output logic             half_tick
);
  localparam int PW = $clog2(PS_HI);

  logic [PW-1:0]    pre;
  logic [DIV_W-1:0] cnt;
  logic             tick;

  // prescaler: code 00 ticks every cycle, 11 falls back to the largest factor
  always_comb begin
    case (sel)
      2'b00:   tick = 1'b1;
      2'b01:   tick = (pre == PW'(PS_MID - 1));
      default: tick = (pre == PW'(PS_HI - 1));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart)   pre <= '0;
    else if (run) begin
      if (tick)           pre <= '0;
      else                pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (restart)          cnt <= div;
    else if (run && tick)      cnt <= (cnt == '0) ? div : cnt - 1'b1;
  end

  assign half_tick = run && tick && (cnt == '0);
endmodule

// File: rtl/sio_edge.sv
module sio_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic idle_lvl,
  output logic launch_ev,
  output logic capture_ev
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign launch_ev  = (sync_q[SYNC-1] != prev_q) && (sync_q[SYNC-1] != idle_lvl);
  assign capture_ev = (sync_q[SYNC-1] != prev_q) && (sync_q[SYNC-1] == idle_lvl);
endmodule

// File: rtl/sio_shift.sv
module sio_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          capture,
  input  logic          msb_first,
  input  logic          sin,
  output logic [DW-1:0] word,
  output logic          out_bit
);
  always_ff @(posedge clk) begin
    if (rst)          word <= '0;
    else if (load)    word <= load_val;
    else if (capture) word <= msb_first ? {word[DW-2:0], sin} : {sin, word[DW-1:1]};
  end

  assign out_bit = msb_first ? word[DW-1] : word[0];
endmodule

// File: rtl/sio_unit.sv
module sio_unit
  import sio_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PS_MID = 8,
  parameter int PS_HI  = 32,
  parameter int SYNC   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          done,
  input  logic          sclk_ext,
  output logic          sclk_out,
  output logic          sclk_oe,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int BCW = $clog2(DW);

  logic [7:0]    ctrl;
  logic [DW-1:0] div_q;
  logic          busy, phase;
  logic [BCW-1:0] bcnt;
  logic          start, half_tick, ext_launch, ext_capture;
  logic          launch, capture, last;
  logic [DW-1:0] word;
  logic          out_bit;
  logic          use_int;

  assign use_int = ctrl[B_INT];
  assign start   = reg_wr && (reg_addr == A_DATA) && !busy;

  sio_clkgen #(.DIV_W(DW), .PS_MID(PS_MID), .PS_HI(PS_HI)) u_clkgen (
    .clk(clk), .rst(rst), .restart(start), .run(busy && use_int),
    .sel(ctrl[1:0]), .div(div_q), .half_tick(half_tick)
  );

  sio_edge #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst(rst), .pin(sclk_ext), .idle_lvl(!ctrl[B_POL]),
    .launch_ev(ext_launch), .capture_ev(ext_capture)
  );

  assign launch  = busy && (use_int ? (half_tick && !phase) : ext_launch);
  assign capture = busy && (use_int ? (half_tick &&  phase) : ext_capture);
  assign last    = capture && (bcnt == BCW'(DW - 1));

  sio_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load(start), .load_val(reg_wdata),
    .capture(capture), .msb_first(ctrl[B_MSB]), .sin(sdi),
    .word(word), .out_bit(out_bit)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= CTRL_RST;
      div_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL)          ctrl  <= reg_wdata[7:0];
      if (reg_addr == A_DIV && !busy)  div_q <= reg_wdata;
    end
  end

  // transfer sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      phase <= 1'b0;
      bcnt  <= '0;
      done  <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        busy  <= 1'b1;
        phase <= 1'b0;
        bcnt  <= '0;
      end else begin
        if (busy && use_int && half_tick) phase <= !phase;
        if (capture)                      bcnt  <= bcnt + 1'b1;
        if (last)                         busy  <= 1'b0;
      end
    end
  end

  // pin-side registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sdo     <= 1'b0;
      sdo_oe  <= 1'b1;
      sclk_oe <= 1'b0;
    end else begin
      if (!ctrl[B_EN])  sdo <= ctrl[B_IDLE];
      else if (launch)  sdo <= out_bit;
      sdo_oe  <= !(ctrl[B_EN] && ctrl[B_HIZ]);
      sclk_oe <= ctrl[B_EN] && ctrl[B_INT];
    end
  end

  assign sclk_out = phase ^ !ctrl[B_POL];

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_DATA:  reg_rdata <= word;
        A_CTRL:  reg_rdata <= DW'(ctrl);
        A_DIV:   reg_rdata <= '0;
        default: reg_rdata <= DW'(busy);
      endcase
    end
  end
endmodule

// File: rtl/sio_unit_chk.sv
module sio_unit_chk
  import sio_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] div_q,
  input logic          sclk_out,
  input logic          pol
);
  // R12
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && reg_addr == A_DATA));
  // R12
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(div_q));
  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sclk_out == !pol));
endmodule

bind sio_unit sio_unit_chk #(.DW(DW)) u_sio_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .busy(busy), .done(done), .div_q(div_q), .sclk_out(sclk_out),
  .pol(ctrl[sio_pkg::B_POL])
);

// File: tb/sio_unit_bench.sv
module sio_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       done, sclk_out, sclk_oe, sdo, sdo_oe;
  logic       sclk_ext = 1'b1;
  logic       sdi = 1'b0;

  sio_unit u_sio_unit (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
    .sclk_ext(sclk_ext), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave-side model
  bit       mon_en = 0, g_pol = 0, g_msb = 0, g_ext = 0;
  bit [7:0] g_stx = 0, sl_rx = 0;
  bit [2:0] sl_idx = 0;
  bit       sl_prev = 0;
  int       done_cnt = 0, done_at = 0;
  always @(negedge clk) begin
    logic line;
    line = g_ext ? sclk_ext : sclk_out;
    if (mon_en && line != sl_prev) begin
      if (line != !g_pol) sdi = g_stx[g_msb ? 3'd7 - sl_idx : sl_idx];
      else begin
        sl_rx[g_msb ? 3'd7 - sl_idx : sl_idx] = sdo;
        sl_idx = sl_idx + 3'd1;
      end
    end
    sl_prev = line;
    if (done) begin done_cnt++; done_at = cyc; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(posedge clk);
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic int pfac(input int sel);
    return sel == 0 ? 1 : (sel == 1 ? 8 : 32);
  endfunction

  task automatic wait_done(input int d0);
    while (done_cnt == d0 && cyc < 150000) @(negedge clk);
  endtask

  // mode 0 plain, 1 mid-transfer intrusion, 2 write on done edge
  task automatic xfer_int(input int sel, input int n, input bit pol, input bit msb,
                          input logic [7:0] tx, input logic [7:0] stx, input int mode);
    int t0, d0, h;
    logic [7:0] rd;
    h = (n + 1) * pfac(sel);
    mon_en = 0;
    g_ext = 0; g_pol = pol; g_msb = msb; g_stx = stx;
    bus_wr(2'd1, {1'b0, 1'b1, msb, pol, 1'b1, 1'b0, 2'(sel)});
    bus_wr(2'd2, 8'(n));
    @(negedge clk); mon_en = 1;
    d0 = done_cnt;
    bus_wr(2'd0, tx);
    t0 = cyc;
    if (mode == 1) begin
      bus_rd(2'd3, rd);
      chk(rd[0] == 1'b1, "R12 busy during transfer", rd[0], 1);
      bus_wr(2'd2, 8'(n + 5));
      bus_wr(2'd0, ~tx);
    end
    if (mode == 2) begin
      repeat (16*h - 1) @(negedge clk);
      reg_addr = 2'd0; reg_wdata = 8'h5A; reg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk); reg_wr = 1'b0;
      chk(done == 1'b1, "R4 done at 16H", done, 1);
    end
    wait_done(d0);
    chk(done_at - t0 == 16*h, "R4/R3 transfer length", done_at - t0, 16*h);
    chk(sl_rx == tx, "R10/R6 byte sent on sdo", sl_rx, tx);
    bus_rd(2'd0, rd);
    chk(rd == stx, "R10/R6 byte received", rd, stx);
    bus_rd(2'd3, rd);
    chk(rd == 8'h00, "R12/R11 idle after done", rd, 0);
    mon_en = 0;
  endtask

  task automatic xfer_ext(input bit pol, input bit msb, input logic [7:0] tx, input logic [7:0] stx);
    int d0;
    logic [7:0] rd;
    mon_en = 0;
    g_ext = 1; g_pol = pol; g_msb = msb; g_stx = stx;
    sclk_ext = !pol;
    bus_wr(2'd1, {1'b0, 1'b0, msb, pol, 1'b1, 1'b0, 2'b00});
    repeat (6) @(negedge clk);
    chk(sclk_oe == 1'b0, "R7 clock not driven in external mode", sclk_oe, 0);
    mon_en = 1;
    d0 = done_cnt;
    bus_wr(2'd0, tx);
    for (int b = 0; b < 8; b++) begin
      repeat (5) @(posedge clk); #1 sclk_ext = pol;
      repeat (10) @(posedge clk); #1 sclk_ext = !pol;
    end
    repeat (10) @(negedge clk);
    chk(done_cnt == d0 + 1, "R7 external transfer completes", done_cnt - d0, 1);
    chk(sl_rx == tx, "R7/R10 external byte sent", sl_rx, tx);
    bus_rd(2'd0, rd);
    chk(rd == stx, "R7/R10 external byte received", rd, stx);
    mon_en = 0; g_ext = 0;
  endtask

  initial begin
    wait (cyc >= 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int k;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done == 0 && sdo == 0 && sdo_oe == 1 && sclk_oe == 0, "R1 pins after reset",
        {done, sdo, sdo_oe, sclk_oe}, 4'b0010);
    bus_rd(2'd1, rd);
    chk(rd == 8'h40, "R1 control reset", rd, 8'h40);
    bus_rd(2'd3, rd);
    chk(rd == 8'h00, "R1 status reset", rd, 0);
    // R9 idle level with serial function off
    bus_wr(2'd1, 8'hC0); @(negedge clk);
    chk(sdo == 1 && sdo_oe == 1, "R9 idle high", {sdo, sdo_oe}, 2'b11);
    bus_wr(2'd1, 8'h40); @(negedge clk);
    chk(sdo == 0 && sdo_oe == 1, "R9 idle low", {sdo, sdo_oe}, 2'b01);
    // R8 tri-state
    bus_wr(2'd1, 8'h4C); @(negedge clk);
    chk(sdo_oe == 0, "R8 output high impedance", sdo_oe, 0);
    chk(sclk_oe == 1, "R7 internal clock driven", sclk_oe, 1);
    bus_wr(2'd1, 8'h04); @(negedge clk);
    chk(sdo_oe == 1, "R8 no effect when function off", sdo_oe, 1);
    // R2 divider reads as zero
    bus_wr(2'd2, 8'h77);
    bus_rd(2'd2, rd);
    chk(rd == 8'h00, "R2 divider write-only", rd, 0);
    // sweep: polarity x order x prescale/divider
    k = 0;
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c < 5; c++) begin
          int sel, n;
          sel = (c == 1) ? 0 : (c < 2 ? 0 : c - 1);
          n   = (c == 1) ? 2 : 0;
          xfer_int(sel, n, p[0], m[0], 8'(8'h35 + 37*k), 8'(8'hC6 ^ (29*k)), 0);
          k++;
        end
    xfer_int(0, 3, 1'b0, 1'b1, 8'hB4, 8'h2D, 1);  // R11 mid-transfer writes
    xfer_int(0, 0, 1'b1, 1'b0, 8'h96, 8'h3C, 2);  // R11 write on done edge
    xfer_ext(1'b0, 1'b1, 8'hE1, 8'h1E);
    xfer_ext(1'b1, 1'b0, 8'h4B, 8'hD2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule